// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small word-addressed memory and serves indivisible read-modify-write operations against it for several requesters. Each requester presents a request with an operation code, a word address, a width flag, an operand and a compare value. A round-robin arbiter admits one request per clock. In the same cycle the unit reads the addressed word, forms the new value and writes it back. On the following clock it returns the word's prior value and the requester's index.

Each word is 64 bits. A request can work on the whole word or only on its low 32 bits. Because admission, read, compute and write-back all happen in one cycle, no other access can reach a word while an operation on it is in progress. The request admitted next always sees the value just written.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Every admitted request gets exactly one response, on the clock after admission. The response carries the admitting requester's index and the value the word held before the update. In narrow mode this value is the low 32 bits, zero-extended. No response appears in a cycle that follows a clock with no admission.
- R2: Operation code 0 stores old + val and code 1 stores old − val. Both wrap modulo the operand width.
- R3: Code 2 stores val unconditionally.
- R4: Codes 3 and 4 store the smaller of old and val, compared signed and unsigned respectively. Codes 5 and 6 store the larger, signed and unsigned respectively.
- R5: Code 7 stores 0 when old >= val (unsigned), and otherwise stores old + 1.
- R6: Code 8 stores val when old is 0 or old > val (unsigned), and otherwise stores old − 1.
- R7: Code 9 stores val only when old equals the compare value. Otherwise the word is left unchanged.
- R8: Codes 10, 11 and 12 store old AND val, old OR val and old XOR val respectively.
- R9: With the width flag low, the operation uses only the low 32 bits of the word, operand and compare value. Signed comparisons take bit 31 as the sign. The upper 32 bits of the word are preserved.
- R10: A wide request with code 1, 7 or 8 sets the error bit in the response and leaves the word unchanged. So does any code from 13 to 15, at either width.
- R11: At most one ready is high in a cycle, and only for a requester whose valid is high. When any valid is high, one ready is high. Requesters that stay valid are served in rotating order, so none waits more than NUM_REQ−1 admissions.
- R12: Requests to the same word take effect in admission order. A write-back is seen by the request admitted in the very next cycle.
- R13: After reset every word reads as zero and no ready or response is asserted while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_REQ | Request present, one bit per requester |
| req_ready | output | NUM_REQ | Request admitted this cycle, one-hot or zero |
| req_op | input | NUM_REQ*4 | Operation code per requester |
| req_addr | input | NUM_REQ*ADDR_W | Word address per requester |
| req_wide | input | NUM_REQ | 1 = 64-bit operation, 0 = low 32 bits |
| req_val | input | NUM_REQ*64 | Operand per requester |
| req_cmp | input | NUM_REQ*64 | Compare value per requester |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | $clog2(NUM_REQ) | Index of the served requester |
| rsp_old | output | 64 | Word value before the update |
| rsp_err | output | 1 | Request rejected, word not written |

## Verification
A corrupted memory word cannot be seen directly. It shows up as a wrong prior value in the response of the next request that touches that address, one clock after that request is admitted. A stuck or skipped arbiter pointer shows within NUM_REQ admissions, as a repeated or missing requester index among simultaneously waiting requesters. A lost narrow-mode merge corrupts the upper half of the word, which becomes visible when a later wide request returns the word. Wrong error decoding shows in the same response as the offending request, and also as an unexpected value at the next access to that word.

// File: rtl/atom_pkg.sv
// Shared operation codes for the atomic unit.
// Assumes a 4-bit code field; codes 13..15 are undefined and rejected.
package atom_pkg;
    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_XCHG  = 4'd2,
        OP_MIN_S = 4'd3,
        OP_MIN_U = 4'd4,
        OP_MAX_S = 4'd5,
        OP_MAX_U = 4'd6,
        OP_INC   = 4'd7,
        OP_DEC   = 4'd8,
        OP_CAS   = 4'd9,
        OP_AND   = 4'd10,
        OP_OR    = 4'd11,
        OP_XOR   = 4'd12
    } atom_op_e;
    localparam int WORD_W = 64;
    localparam int HALF_W = 32;
endpackage

// File: rtl/atom_rr_arbiter.sv
// Round-robin arbiter: grants the first valid requester at or after a rotating
// pointer. Assumes NUM_REQ >= 2. The grant is combinational from the valids.
module atom_rr_arbiter #(
    parameter int NUM_REQ = 4,
    localparam int IW = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] valid,
    output logic [NUM_REQ-1:0] grant,
    output logic [IW-1:0]      win_idx,
    output logic               any_grant
);
    logic [IW-1:0] ptr_q;

    // Search from the pointer for the first valid requester.
    always_comb begin
        grant     = '0;
        win_idx   = '0;
        any_grant = 1'b0;
        for (int k = 0; k < NUM_REQ; k++) begin
            int j;
            j = (int'(ptr_q) + k) % NUM_REQ;
            if (!any_grant && valid[j]) begin
                any_grant = 1'b1;
                grant[j]  = 1'b1;
                win_idx   = IW'(j);
            end
        end
    end

    // Move the pointer past the winner after each admission.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (any_grant)
            ptr_q <= (win_idx == IW'(NUM_REQ - 1)) ? '0 : win_idx + 1'b1;
    end
endmodule

// File: rtl/atom_alu.sv
// Computes the new word value for one atomic request from the old word.
// Narrow mode works on bits 31:0 and keeps the upper half of the word.
// Flags an error (no write) for wide SUB/INC/DEC and undefined codes.
module atom_alu
    import atom_pkg::*;
(
    input  logic [3:0]        op,
    input  logic              wide,
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] val,
    input  logic [WORD_W-1:0] cmp,
    output logic [WORD_W-1:0] new_word,
    output logic [WORD_W-1:0] old_rsp,
    output logic              err
);
    logic [WORD_W-1:0] a, b, c, sa, sb, res;

    // Width-adjust operands, apply the operation, merge the narrow result.
    always_comb begin
        a   = wide ? old_word : {{HALF_W{1'b0}}, old_word[HALF_W-1:0]};
        b   = wide ? val      : {{HALF_W{1'b0}}, val[HALF_W-1:0]};
        c   = wide ? cmp      : {{HALF_W{1'b0}}, cmp[HALF_W-1:0]};
        sa  = wide ? old_word : {{HALF_W{old_word[HALF_W-1]}}, old_word[HALF_W-1:0]};
        sb  = wide ? val      : {{HALF_W{val[HALF_W-1]}}, val[HALF_W-1:0]};
        res = a;
        err = 1'b0;
        case (atom_op_e'(op))
            OP_ADD:   res = a + b;
            OP_SUB:   if (wide) err = 1'b1; else res = a - b;
            OP_XCHG:  res = b;
            OP_MIN_S: res = ($signed(sa) < $signed(sb)) ? a : b;
            OP_MIN_U: res = (a < b) ? a : b;
            OP_MAX_S: res = ($signed(sa) > $signed(sb)) ? a : b;
            OP_MAX_U: res = (a > b) ? a : b;
            OP_INC:   if (wide) err = 1'b1; else res = (a >= b) ? '0 : a + 1'b1;
            OP_DEC:   if (wide) err = 1'b1; else res = (a == '0 || a > b) ? b : a - 1'b1;
            OP_CAS:   res = (a == c) ? b : a;
            OP_AND:   res = a & b;
            OP_OR:    res = a | b;
            OP_XOR:   res = a ^ b;
            default:  err = 1'b1;
        endcase
        new_word = wide ? res : {old_word[WORD_W-1:HALF_W], res[HALF_W-1:0]};
        old_rsp  = a;
    end
endmodule

// File: rtl/atom_mem.sv
// Register-based word store: combinational read, one synchronous write port.
// Assumes a small depth; all words clear to zero on reset.
module atom_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 64,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] words_q [DEPTH];

    // Read the addressed word.
    assign rdata = words_q[addr];

    // Clear on reset, otherwise write back the updated word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
        end else if (we) begin
            words_q[addr] <= wdata;
        end
    end
endmodule

// File: rtl/atomic_rmw_unit.sv
// Atomic read-modify-write unit. One request is admitted per clock. It is read,
// updated and written back in that cycle, so operations are indivisible and the
// next admission sees the result. Response registered one clock later; the
// receiver is assumed always able to take it.
module atomic_rmw_unit
    import atom_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W  = 4,
    localparam int IW = $clog2(NUM_REQ)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_REQ-1:0]          req_valid,
    output logic [NUM_REQ-1:0]          req_ready,
    input  logic [NUM_REQ*4-1:0]        req_op,
    input  logic [NUM_REQ*ADDR_W-1:0]   req_addr,
    input  logic [NUM_REQ-1:0]          req_wide,
    input  logic [NUM_REQ*WORD_W-1:0]   req_val,
    input  logic [NUM_REQ*WORD_W-1:0]   req_cmp,
    output logic                        rsp_valid,
    output logic [IW-1:0]               rsp_id,
    output logic [WORD_W-1:0]           rsp_old,
    output logic                        rsp_err
);
    logic [NUM_REQ-1:0] grant;
    logic [IW-1:0]      win_idx;
    logic               fire;
    logic [3:0]         s_op;
    logic [ADDR_W-1:0]  s_addr;
    logic               s_wide;
    logic [WORD_W-1:0]  s_val, s_cmp, rd_word, wr_word, old_rsp;
    logic               alu_err;

    atom_rr_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
        .clk(clk), .rst_n(rst_n), .valid(req_valid & {NUM_REQ{rst_n}}),
        .grant(grant), .win_idx(win_idx), .any_grant(fire)
    );

    assign req_ready = grant;

    // Select the winning requester's fields.
    always_comb begin
        s_op   = req_op[win_idx*4 +: 4];
        s_addr = req_addr[win_idx*ADDR_W +: ADDR_W];
        s_wide = req_wide[win_idx];
        s_val  = req_val[win_idx*WORD_W +: WORD_W];
        s_cmp  = req_cmp[win_idx*WORD_W +: WORD_W];
    end

    atom_mem #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .addr(s_addr), .rdata(rd_word),
        .we(fire && !alu_err), .wdata(wr_word)
    );

    atom_alu u_alu (
        .op(s_op), .wide(s_wide), .old_word(rd_word), .val(s_val), .cmp(s_cmp),
        .new_word(wr_word), .old_rsp(old_rsp), .err(alu_err)
    );

    // Register the response for the admitted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
            rsp_old   <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                rsp_id  <= win_idx;
                rsp_old <= old_rsp;
                rsp_err <= alu_err;
            end
        end
    end
endmodule

// File: rtl/atomic_rmw_checker.sv
// Protocol checker for atomic_rmw_unit, bound to every instance.
module atomic_rmw_checker #(
    parameter int NUM_REQ = 4,
    localparam int IW = $clog2(NUM_REQ)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_REQ-1:0]   req_valid,
    input logic [NUM_REQ-1:0]   req_ready,
    input logic [NUM_REQ*4-1:0] req_op,
    input logic [NUM_REQ-1:0]   req_wide,
    input logic                 rsp_valid,
    input logic [IW-1:0]        rsp_id,
    input logic                 rsp_err
);
    logic [3:0]    c_op;
    logic          c_wide;
    logic [IW-1:0] c_id;
    logic          c_fire;

    // Recover the admitted request's fields from the ready vector.
    always_comb begin
        c_op = '0; c_wide = 1'b0; c_id = '0;
        for (int k = 0; k < NUM_REQ; k++) begin
            if (req_ready[k]) begin
                c_op = req_op[k*4 +: 4]; c_wide = req_wide[k]; c_id = IW'(k);
            end
        end
        c_fire = |req_ready;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_ready)); // R11
    AST_GRANT_VALID: assert property (@(posedge clk) disable iff (!rst_n) (req_ready & ~req_valid) == '0); // R11
    AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n) (|req_valid) |-> c_fire); // R11
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) c_fire |=> (rsp_valid && rsp_id == $past(c_id))); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !c_fire |=> !rsp_valid); // R1
    AST_WIDE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (c_fire && c_wide && (c_op == 4'd1 || c_op == 4'd7 || c_op == 4'd8)) |=> rsp_err); // R10
endmodule

bind atomic_rmw_unit atomic_rmw_checker #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_wide(req_wide), .rsp_valid(rsp_valid),
    .rsp_id(rsp_id), .rsp_err(rsp_err)
);

// File: tb/atomic_rmw_unit_bench.sv
`timescale 1ns/1ps
module atomic_rmw_unit_bench;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]      req_valid = '0;
    logic [N-1:0]      req_ready;
    logic [N*4-1:0]    req_op = '0;
    logic [N*AW-1:0]   req_addr = '0;
    logic [N-1:0]      req_wide = '0;
    logic [N*64-1:0]   req_val = '0;
    logic [N*64-1:0]   req_cmp = '0;
    logic              rsp_valid;
    logic [IW-1:0]     rsp_id;
    logic [63:0]       rsp_old;
    logic              rsp_err;

    int checks = 0;
    int errors = 0;
    logic [63:0] model [16];

    always #2.5 clk = ~clk;

    atomic_rmw_unit #(.NUM_REQ(N), .ADDR_W(AW)) u_atomic_rmw_unit (.*);

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Reference behaviour from the requirements.
    function automatic void ref_op(input logic [3:0] op, input bit w, input logic [63:0] old,
                                   input logic [63:0] v, input logic [63:0] c,
                                   output logic [63:0] nw, output bit err);
        logic [63:0] a, b, cc, r;
        logic signed [63:0] sa, sb;
        a  = w ? old : {32'd0, old[31:0]};
        b  = w ? v : {32'd0, v[31:0]};
        cc = w ? c : {32'd0, c[31:0]};
        sa = w ? old : {{32{old[31]}}, old[31:0]};
        sb = w ? v : {{32{v[31]}}, v[31:0]};
        err = 0; r = a;
        case (op)
            0: r = a + b;
            1: if (w) err = 1; else r = a - b;
            2: r = b;
            3: r = (sa < sb) ? a : b;
            4: r = (a < b) ? a : b;
            5: r = (sa > sb) ? a : b;
            6: r = (a > b) ? a : b;
            7: if (w) err = 1; else r = (a >= b) ? 64'd0 : a + 1;
            8: if (w) err = 1; else r = (a == 0 || a > b) ? b : a - 1;
            9: r = (a == cc) ? b : a;
            10: r = a & b;
            11: r = a | b;
            12: r = a ^ b;
            default: err = 1;
        endcase
        nw = err ? old : (w ? r : {old[63:32], r[31:0]});
    endfunction

    // Issue one request from requester r and check its response.
    task automatic run(string tag, int r, logic [3:0] op, int ad, bit w,
                       logic [63:0] v, logic [63:0] c);
        logic [63:0] nw, exp_old;
        bit e;
        ref_op(op, w, model[ad], v, c, nw, e);
        exp_old = w ? model[ad] : {32'd0, model[ad][31:0]};
        @(negedge clk);
        req_valid[r] = 1'b1;
        req_op[r*4 +: 4] = op;
        req_addr[r*AW +: AW] = AW'(ad);
        req_wide[r] = w;
        req_val[r*64 +: 64] = v;
        req_cmp[r*64 +: 64] = c;
        #1;
        while (!req_ready[r]) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid[r] = 1'b0;
        chk({tag, " rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
        chk({tag, " id"}, {62'd0, rsp_id}, 64'(r));
        chk({tag, " old"}, rsp_old, exp_old);
        chk({tag, " err"}, {63'd0, rsp_err}, {63'd0, e});
        model[ad] = nw;
    endtask

    task automatic t_reset();
        chk("R13 ready in reset", {60'd0, req_ready}, 64'd0);
        chk("R13 rsp in reset", {63'd0, rsp_valid}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) model[i] = 64'd0;
        run("R13 word zero", 0, 4'd2, 5, 1, 64'h1111_2222_3333_4444, 0);
    endtask

    task automatic t_arith();
        run("R2 add wide", 1, 4'd0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        run("R2 add wrap", 1, 4'd0, 1, 1, 64'd2, 0);
        run("R2 sub narrow", 2, 4'd1, 1, 0, 64'd5, 0);
        run("R9 read back", 3, 4'd2, 1, 1, 64'd0, 0);
        run("R3 xchg", 0, 4'd2, 2, 1, 64'hDEAD_BEEF_0000_0001, 0);
        run("R3 xchg readback", 0, 4'd2, 2, 1, 64'd7, 0);
    endtask

    task automatic t_minmax();
        run("R4 seed", 0, 4'd2, 3, 1, 64'd10, 0);
        run("R4 min signed", 1, 4'd3, 3, 1, 64'hFFFF_FFFF_FFFF_FFF0, 0);
        run("R4 min unsigned", 1, 4'd4, 3, 1, 64'd3, 0);
        run("R4 max signed narrow", 2, 4'd5, 3, 0, 64'h0000_0000_8000_0000, 0);
        run("R4 max unsigned narrow", 2, 4'd6, 3, 0, 64'h0000_0000_8000_0000, 0);
        run("R4 min signed narrow", 3, 4'd3, 3, 0, 64'h0000_0000_FFFF_FFFF, 0);
        run("R4 readback", 3, 4'd2, 3, 1, 64'd0, 0);
    endtask

    task automatic t_incdec();
        run("R5 inc", 0, 4'd7, 4, 0, 64'd2, 0);
        run("R5 inc", 0, 4'd7, 4, 0, 64'd2, 0);
        run("R5 inc wrap", 0, 4'd7, 4, 0, 64'd2, 0);
        run("R6 dec zero", 1, 4'd8, 4, 0, 64'd9, 0);
        run("R6 dec", 1, 4'd8, 4, 0, 64'd9, 0);
        run("R6 dec above", 1, 4'd8, 4, 0, 64'd3, 0);
        run("R6 readback", 1, 4'd2, 4, 0, 64'd0, 0);
    endtask

    task automatic t_cas_logic();
        run("R7 seed", 2, 4'd2, 6, 1, 64'hA5A5_0000_0000_00F0, 0);
        run("R7 cas miss", 2, 4'd9, 6, 1, 64'd1, 64'd0);
        run("R7 cas hit", 2, 4'd9, 6, 1, 64'h0F0F, 64'hA5A5_0000_0000_00F0);
        run("R8 and", 3, 4'd10, 6, 1, 64'h00FF, 0);
        run("R8 or", 3, 4'd11, 6, 1, 64'hF000_0000_0000_0000, 0);
        run("R8 xor", 3, 4'd12, 6, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        run("R9 narrow keeps upper", 0, 4'd12, 6, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        run("R8 readback", 0, 4'd2, 6, 1, 64'd0, 0);
    endtask

    task automatic t_errors();
        run("R10 seed", 1, 4'd2, 7, 1, 64'h1_0000_0005, 0);
        run("R10 wide sub", 1, 4'd1, 7, 1, 64'd1, 0);
        run("R10 wide inc", 1, 4'd7, 7, 1, 64'd100, 0);
        run("R10 wide dec", 1, 4'd8, 7, 1, 64'd100, 0);
        run("R10 bad code", 1, 4'd14, 7, 0, 64'd100, 0);
        run("R10 unchanged", 1, 4'd2, 7, 1, 64'd0, 0);
    endtask

    // Three requesters add 1 to one word at once: rotating service, serial results.
    task automatic t_contention();
        logic [N-1:0] seen = '0;
        int got_cnt = 0;
        logic [63:0] base;
        logic [IW-1:0] last_id;
        base = model[9];
        @(negedge clk);
        for (int r = 0; r < 3; r++) begin
            req_op[r*4 +: 4] = 4'd0; req_addr[r*AW +: AW] = 4'd9;
            req_wide[r] = 1'b1; req_val[r*64 +: 64] = 64'd1;
        end
        req_valid[2:0] = 3'b111;
        for (int cyc = 0; cyc < 4; cyc++) begin
            #1;
            chk("R11 onehot ready", {63'd0, 1'($countones(req_ready) <= 1)}, 64'd1);
            last_id = '0;
            for (int r = 0; r < N; r++) if (req_ready[r]) last_id = IW'(r);
            @(negedge clk);
            if (rsp_valid) begin
                chk("R12 serial old", rsp_old, base + 64'(got_cnt));
                chk("R11 no repeat", {63'd0, seen[rsp_id]}, 64'd0);
                seen[rsp_id] = 1'b1;
                req_valid[rsp_id] = 1'b0;
                got_cnt++;
            end
        end
        chk("R11 all served", {61'd0, seen[2:0]}, 64'd7);
        model[9] = base + 3;
        run("R12 final", 3, 4'd2, 9, 1, 64'd0, 0);
    endtask

    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_arith();
        t_minmax();
        t_incdec();
        t_cas_logic();
        t_errors();
        t_contention();
        @(negedge clk);
        chk("R1 idle no rsp", {63'd0, rsp_valid}, 64'd0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule